// File: doc/BRIEF.md
# Dual signed halfword multiply-accumulate

This datapath unit treats each of two 32-bit operands as a pair of signed 16-bit halves. It multiplies the halves in pairs, low with low and high with high. It then combines the two products either by adding them or by subtracting the high product from the low one. A control bit can swap the two halves of the second operand before the products are formed, which crosses the pairing. An optional 32-bit accumulator can then be added to the combined value. Every result wraps modulo 2^32.

Signed overflow at the addition points is recorded in a sticky saturation flag (Q). In sum mode there are two such points: the addition of the products, and the addition of the accumulator. In difference mode only the accumulator addition is checked. The unit never clears Q. Only the synchronous clear pin clears it.

Operations enter through a valid/ready handshake. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is held in a single output register until the consumer takes it with `res_ready`. `in_ready` is high whenever that register is empty or is being drained in the same cycle. While `res_valid` is high and `res_ready` is low, the result stays unchanged and no new operation is accepted.

Top module: `dmac_unit`

## Requirements
- R1: Bits [15:0] of an operand form its signed low half and bits [31:16] its signed high half. With `op_sub`=0, `exch`=0 and `acc_en`=0, the result is lo(a)*lo(b) + hi(a)*hi(b), wrapped to 32 bits.
- R2: With `exch`=1, the halves of `opnd_b` are swapped first, so the products become lo(a)*hi(b) and hi(a)*lo(b).
- R3: With `op_sub`=1, the result is the low product minus the high product. When `acc_en`=1, `acc_in` is added to it. The result wraps modulo 2^32 and is never clamped.
- R4: In sum mode, signed overflow of the product addition sets Q, whether or not the accumulator is used.
- R5: With `acc_en`=1, signed overflow of the accumulator addition sets Q in either mode.
- R6: In difference mode with `acc_en`=0, Q is never changed.
- R7: Once set, Q stays 1 until `q_clr` is asserted. No operation lowers Q.
- R8: A cycle with `q_clr`=1 drives Q to 0 on that edge. If an operation that overflows is accepted on the same edge, Q ends at 1.
- R9: An operation accepted on an edge shows its result with `res_valid`=1 right after that edge. Q includes that operation's overflow from the same edge.
- R10: While `res_valid`=1 and `res_ready`=0, `res` and `res_valid` hold and `in_ready` is 0. `in_ready` is 1 whenever `res_valid`=0 or `res_ready`=1.
- R11: After reset, `res_valid`=0, `q_flag`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| op_sub | input | 1 | 0: sum of products, 1: difference |
| exch | input | 1 | Swap halves of opnd_b |
| acc_en | input | 1 | Add acc_in |
| opnd_a | input | 32 | First operand, two signed halves |
| opnd_b | input | 32 | Second operand, two signed halves |
| acc_in | input | 32 | Accumulator value |
| res_valid | output | 1 | Result register holds a result |
| res_ready | input | 1 | Consumer takes the result |
| res | output | 32 | Wrapped 32-bit result |
| q_clr | input | 1 | Synchronous clear of Q |
| q_flag | output | 1 | Sticky overflow flag |

## Verification
The clear of Q and the setting of Q by an accepted operation can land on the same edge. The bench provokes this by raising `q_clr` in the cycle where an overflowing sum of two most-negative half products is accepted. It judges the outcome by requiring Q to read 1 after that edge. Two further checks bound this case. A clear with no operation must give 0. A clear together with a non-overflowing operation must also give 0.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  typedef logic signed [WORD_W-1:0] word_t;
endpackage

// File: rtl/dmac_halfmul.sv
module dmac_halfmul #(
  parameter int HW = 16,
  localparam int WW = 2 * HW
) (
  input  logic [WW-1:0]        a,
  input  logic [WW-1:0]        b,
  input  logic                 exch,
  output logic signed [WW-1:0] prod_lo,
  output logic signed [WW-1:0] prod_hi
);
  logic signed [WW-1:0] prods [2];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [HW-1:0]        ha, hb;
    logic signed [WW-1:0] xa, xb;
    always_comb begin
      ha = a[g*HW +: HW];
      hb = exch ? b[(1-g)*HW +: HW] : b[g*HW +: HW];
      xa = {{HW{ha[HW-1]}}, ha};
      xb = {{HW{hb[HW-1]}}, hb};
    end
    assign prods[g] = xa * xb;
  end

  assign prod_lo = prods[0];
  assign prod_hi = prods[1];
endmodule

// File: rtl/dmac_combine.sv
module dmac_combine #(
  parameter int WW = 32
) (
  input  logic signed [WW-1:0] prod_lo,
  input  logic signed [WW-1:0] prod_hi,
  input  logic [WW-1:0]        acc,
  input  logic                 sub,
  input  logic                 acc_en,
  output logic [WW-1:0]        result,
  output logic                 ovf
);
  localparam int M = WW - 1;
  logic [WW-1:0] s1, s2;
  logic          ov_pair, ov_acc;

  always_comb begin
    s1      = sub ? prod_lo - prod_hi : prod_lo + prod_hi;
    ov_pair = !sub && (prod_lo[M] == prod_hi[M]) && (s1[M] != prod_lo[M]);
    s2      = s1 + acc;
    ov_acc  = acc_en && (s1[M] == acc[M]) && (s2[M] != s1[M]);
    result  = acc_en ? s2 : s1;
    ovf     = ov_pair | ov_acc;
  end
endmodule

// File: rtl/dmac_unit.sv
module dmac_unit #(
  parameter int HW = dmac_pkg::HALF_W,
  localparam int WW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          op_sub,
  input  logic          exch,
  input  logic          acc_en,
  input  logic [WW-1:0] opnd_a,
  input  logic [WW-1:0] opnd_b,
  input  logic [WW-1:0] acc_in,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [WW-1:0] res,
  input  logic          q_clr,
  output logic          q_flag
);
  logic signed [WW-1:0] p_lo, p_hi;
  logic [WW-1:0]        sum_w;
  logic                 ovf_w, take;

  dmac_halfmul #(.HW(HW)) u_mul (
    .a(opnd_a), .b(opnd_b), .exch(exch), .prod_lo(p_lo), .prod_hi(p_hi)
  );

  dmac_combine #(.WW(WW)) u_comb (
    .prod_lo(p_lo), .prod_hi(p_hi), .acc(acc_in), .sub(op_sub),
    .acc_en(acc_en), .result(sum_w), .ovf(ovf_w)
  );

  assign in_ready = !res_valid || res_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res       <= '0;
      q_flag    <= 1'b0;
    end else begin
      if (take) begin
        res_valid <= 1'b1;
        res       <= sum_w;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
      q_flag <= (q_flag && !q_clr) || (take && ovf_w);
    end
  end
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int WW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          op_sub,
  input logic          acc_en,
  input logic          res_valid,
  input logic          res_ready,
  input logic [WW-1:0] res,
  input logic          q_clr,
  input logic          q_flag
);
  // R7
  q_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_flag && !q_clr) |=> q_flag);

  // R8
  q_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_clr && !(in_valid && in_ready)) |=> !q_flag);

  // R6
  diff_noacc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && op_sub && !acc_en && !q_flag && !q_clr) |=> !q_flag);

  // R9
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> res_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res)));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !in_ready);
endmodule

bind dmac_unit dmac_chk #(.WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op_sub(op_sub), .acc_en(acc_en), .res_valid(res_valid),
  .res_ready(res_ready), .res(res), .q_clr(q_clr), .q_flag(q_flag)
);

// File: tb/dmac_unit_tb.sv
module dmac_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, op_sub = 0, exch = 0, acc_en = 0, res_ready = 1, q_clr = 0;
  logic [31:0] opnd_a = 0, opnd_b = 0, acc_in = 0;
  logic in_ready, res_valid, q_flag;
  logic [31:0] res;
  int vectors = 0, miscompares = 0;
  logic qm = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  dmac_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sub(op_sub), .exch(exch), .acc_en(acc_en), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .acc_in(acc_in), .res_valid(res_valid),
    .res_ready(res_ready), .res(res), .q_clr(q_clr), .q_flag(q_flag)
  );

  function automatic longint sx16(input logic [15:0] h);
    return longint'(signed'(h));
  endfunction

  function automatic bit ovr(input longint v);
    return (v > 64'sd2147483647) || (v < -64'sd2147483648);
  endfunction

  task automatic model(input logic [31:0] a, b, acc, input logic sub, ex, ae,
                       output logic [31:0] r, output logic qs);
    longint al, ah, bl, bh, pl, ph, t;
    logic [31:0] s1;
    al = sx16(a[15:0]); ah = sx16(a[31:16]);
    bl = ex ? sx16(b[31:16]) : sx16(b[15:0]);
    bh = ex ? sx16(b[15:0]) : sx16(b[31:16]);
    pl = al * bl; ph = ah * bh; qs = 0;
    if (sub) t = pl - ph;
    else begin t = pl + ph; if (ovr(t)) qs = 1; end
    s1 = t[31:0];
    r = s1;
    if (ae) begin
      t = longint'(signed'(s1)) + longint'(signed'(acc));
      if (ovr(t)) qs = 1;
      r = t[31:0];
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One operation, consumer ready; checks result and Q after the accept edge.
  task automatic run_op(input string req, input logic [31:0] a, b, acc,
                        input logic sub, ex, ae, input logic clr);
    logic [31:0] er; logic qs;
    model(a, b, acc, sub, ex, ae, er, qs);
    @(negedge clk);
    opnd_a = a; opnd_b = b; acc_in = acc; op_sub = sub; exch = ex; acc_en = ae;
    q_clr = clr; in_valid = 1; res_ready = 1;
    @(negedge clk);
    in_valid = 0; q_clr = 0;
    qm = (qm && !clr) || qs;
    chk(res_valid === 1'b1, {req, " valid"}, {31'b0, res_valid}, 32'd1);
    chk(res === er, {req, " result"}, res, er);
    chk(q_flag === qm, {req, " q"}, {31'b0, q_flag}, {31'b0, qm});
  endtask

  task automatic t_reset;
    chk(res_valid === 1'b0, "R11 res_valid", {31'b0, res_valid}, 0);
    chk(q_flag === 1'b0, "R11 q_flag", {31'b0, q_flag}, 0);
    chk(in_ready === 1'b1, "R11 in_ready", {31'b0, in_ready}, 1);
  endtask

  task automatic t_clear_only;
    @(negedge clk); q_clr = 1;
    @(negedge clk); q_clr = 0; qm = 0;
    chk(q_flag === 1'b0, "R8 clear alone", {31'b0, q_flag}, 0);
  endtask

  task automatic t_stall;
    logic [31:0] e1, e2; logic qs;
    model(32'h0003_0002, 32'h0005_0004, 0, 0, 0, 0, e1, qs);
    model(32'h0001_0001, 32'h0002_0003, 32'd10, 1, 0, 1, e2, qs);
    @(negedge clk);
    res_ready = 0; opnd_a = 32'h0003_0002; opnd_b = 32'h0005_0004;
    op_sub = 0; exch = 0; acc_en = 0; in_valid = 1;
    @(negedge clk);
    opnd_a = 32'h0001_0001; opnd_b = 32'h0002_0003; acc_in = 32'd10;
    op_sub = 1; acc_en = 1;
    for (int i = 0; i < 2; i++) begin
      chk(in_ready === 1'b0, "R10 blocked", {31'b0, in_ready}, 0);
      chk(res === e1, "R10 held", res, e1);
      @(negedge clk);
    end
    res_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(res_valid === 1'b1 && res === e2, "R10 next after drain", res, e2);
    @(negedge clk);
    chk(res_valid === 1'b0, "R10 drained", {31'b0, res_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_op("R1 sum",       32'h0003_FFFE, 32'h0007_0005, 0, 0, 0, 0, 0);
    run_op("R2 exchange",  32'h0003_FFFE, 32'h0007_0005, 0, 0, 1, 0, 0);
    run_op("R3 diff",      32'h0002_0010, 32'hFFFF_0003, 0, 1, 0, 0, 0);
    run_op("R3 diff acc",  32'h0004_0001, 32'h0004_0001, 32'hFFFF_FFF0, 1, 1, 1, 0);
    run_op("R6 diff noacc",32'h7FFF_8000, 32'h8000_8000, 0, 1, 0, 0, 0);
    run_op("R4 pair ovf",  32'h8000_8000, 32'h8000_8000, 0, 0, 0, 0, 0);
    run_op("R7 sticky",    32'h0001_0001, 32'h0001_0001, 0, 0, 0, 0, 0);
    t_clear_only();
    run_op("R5 acc ovf sum",  32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFF, 0, 0, 1, 0);
    run_op("R8 clr no ovf",   32'h0000_0001, 32'h0000_0001, 0, 0, 0, 0, 1);
    run_op("R5 acc ovf diff", 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFF, 1, 0, 1, 0);
    run_op("R8 clr with ovf", 32'h8000_8000, 32'h8000_8000, 0, 0, 0, 0, 1);
    run_op("R9 wrap acc",     32'h8000_8000, 32'h8000_8000, 32'h8000_0000, 0, 0, 1, 0);
    t_stall();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule